// File: doc/BRIEF.md
# Nibble ALU Execute Stage

This block is the execute stage of a small 4-bit controller. It accepts one 16-bit instruction word per cycle, qualified by a valid strobe, and carries out the arithmetic, comparison and logic group of the instruction set. Each instruction names one memory nibble through a row and a column field combined with the current bank. It also names either a working register or a 4-bit immediate. Working registers are the first sixteen nibbles of bank 0. The block reads its operands from the data memory and computes a result. It writes the result back through a registered write port, keeps a single carry/borrow flag, and raises a skip pulse that tells the fetch logic to cancel the following instruction.

The memory is outside the block. The block presents two read addresses, one for the memory operand and one for the register operand, and expects the read data back in the same cycle. A result is written one cycle after the instruction is accepted. An instruction that immediately follows a writer would otherwise read the old value, so a bypass hands it the pending result instead. Fetch, jumps, the stack, I/O and data transfer instructions are handled elsewhere.

Top module: `nib_alu_exec`

## Requirements
- R1: Instruction fields are opcode in bits 15:10, row in 9:8, column in 7:4 and register number or immediate in 3:0. The memory operand address is {bank_i, row, column}. The register operand address is {0, 0, register number} whatever bank_i holds. Write addresses use the same encodings.
- R2: Opcodes 010xyz add. Bit 2 (z-side form bit) set means M ← M + I, and clear means r ← r + M. Bit 1 adds the carry flag in. Bit 0 enables the skip. The 4-bit sum is written to the destination.
- R3: Opcodes 011xyz subtract, using the same three bits as R2. M ← M − I or r ← r − M, and bit 1 also subtracts the borrow flag.
- R4: The flag resets to 0. An add loads it with the carry out and a subtract loads it with the borrow. Compare, logic and unknown opcodes and idle cycles leave it unchanged.
- R5: An add or subtract with bit 0 set pulses skip_o exactly when it produces a carry or borrow. With bit 0 clear it never skips.
- R6: The compare opcodes write nothing. 000100 skips when r = M. 000101 skips when M = I. 000001 skips when M ≠ I. 000110 skips when r ≥ M. 000111 skips when M ≥ I. 000011 skips when M < I (all unsigned).
- R7: Logic opcodes 001000/001001 AND, 001010/001011 OR and 001100/001101 XOR never skip. The even opcode gives r ← r op M and the odd one gives M ← M op I.
- R8: Any other opcode (including 000000, 000010, 001110, 001111 and 1xxxxx) causes no write and no skip.
- R9: Write and skip appear as single-cycle pulses in the cycle after the accepting clock edge. A cycle with instr_valid_i low produces neither.
- R10: An instruction accepted in the cycle where the previous result is still pending reads that result for any operand whose address matches the write address.
- R11: During and right after reset, mem_we_o, skip_o and carry_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 16 | Instruction word |
| bank_i | input | 2 | Current data bank for the memory operand |
| mem_m_raddr_o | output | 8 | Memory operand read address |
| mem_m_rdata_i | input | 4 | Memory operand read data (same cycle) |
| mem_r_raddr_o | output | 8 | Register operand read address |
| mem_r_rdata_i | input | 4 | Register operand read data (same cycle) |
| mem_we_o | output | 1 | Result write strobe |
| mem_waddr_o | output | 8 | Result write address |
| mem_wdata_o | output | 4 | Result write data |
| skip_o | output | 1 | Cancel-next-instruction pulse |
| carry_o | output | 1 | Carry/borrow flag |

## Verification
The bench walks a zeroed nibble through the wrap points. Adding 15 to 0 must not carry, and adding 1 to 15 must carry and skip. Subtracting 1 from 0 must borrow. A design with the borrow polarity inverted, or with the carry taken from the wrong bit, fails there. Chained carry-in instructions check that the flag left by the previous add or subtract is consumed. Compares at equal values and at the unsigned boundary catch an equality test that is off by one, or a greater-or-equal test that slips to strictly greater. Register operands issued with a non-zero bank catch a register address that wrongly follows the bank. Back-to-back instructions on the same nibble catch a missing or mis-addressed bypass, which would show up as a stale result.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

   localparam int OPC_W = 6;

   typedef enum logic [2:0] {
      CLS_NONE,
      CLS_ADD,
      CLS_SUB,
      CLS_CMP,
      CLS_LOG
   } op_cls_e;

   typedef enum logic [1:0] {
      CMP_EQ,
      CMP_NE,
      CMP_GE,
      CMP_LT
   } cmp_kind_e;

   typedef enum logic [1:0] {
      LOG_AND,
      LOG_OR,
      LOG_XOR
   } log_kind_e;

   typedef struct packed {
      op_cls_e   cls;
      logic      use_imm;
      logic      use_cin;
      logic      skip_en;
      logic      wr_en;
      logic      upd_flag;
      cmp_kind_e cmp;
      log_kind_e lg;
   } dec_t;

endpackage

// File: rtl/nib_decode.sv
module nib_decode
   import nib_alu_pkg::*;
(
   input  logic [OPC_W-1:0] opc_i,
   output dec_t             dec_o
);

   always_comb begin
      dec_o          = '0;
      dec_o.cls      = CLS_NONE;
      dec_o.cmp      = CMP_EQ;
      dec_o.lg       = LOG_AND;
      case (opc_i[5:3])
         3'b010, 3'b011: begin
            dec_o.cls      = opc_i[3] ? CLS_SUB : CLS_ADD;
            dec_o.use_imm  = opc_i[2];
            dec_o.use_cin  = opc_i[1];
            dec_o.skip_en  = opc_i[0];
            dec_o.wr_en    = 1'b1;
            dec_o.upd_flag = 1'b1;
         end
         3'b000: begin
            dec_o.use_imm = opc_i[0];
            case (opc_i[2:0])
               3'b100, 3'b101: begin dec_o.cls = CLS_CMP; dec_o.cmp = CMP_EQ; end
               3'b001:         begin dec_o.cls = CLS_CMP; dec_o.cmp = CMP_NE; end
               3'b110, 3'b111: begin dec_o.cls = CLS_CMP; dec_o.cmp = CMP_GE; end
               3'b011:         begin dec_o.cls = CLS_CMP; dec_o.cmp = CMP_LT; end
               default:        dec_o.use_imm = 1'b0;
            endcase
         end
         3'b001: begin
            if (opc_i[2:1] != 2'b11) begin
               dec_o.cls     = CLS_LOG;
               dec_o.use_imm = opc_i[0];
               dec_o.wr_en   = 1'b1;
               case (opc_i[2:1])
                  2'b00:   dec_o.lg = LOG_AND;
                  2'b01:   dec_o.lg = LOG_OR;
                  default: dec_o.lg = LOG_XOR;
               endcase
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/nib_arith.sv
module nib_arith
   import nib_alu_pkg::*;
#(
   parameter int DATA_W = 4
) (
   input  dec_t              dec_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              flag_i,
   output logic [DATA_W-1:0] res_o,
   output logic              flag_o,
   output logic              skip_o
);

   logic              sub_mode;
   logic              cin_eff;
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   chain;
   logic [DATA_W-1:0] sum;
   logic              zero;

   assign sub_mode = (dec_i.cls == CLS_SUB) || (dec_i.cls == CLS_CMP);
   assign cin_eff  = dec_i.use_cin & flag_i;
   assign b_eff    = sub_mode ? ~b_i : b_i;
   assign chain[0] = sub_mode ? ~cin_eff : cin_eff;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign sum[i]     = a_i[i] ^ b_eff[i] ^ chain[i];
      assign chain[i+1] = (a_i[i] & b_eff[i]) | (chain[i] & (a_i[i] ^ b_eff[i]));
   end

   assign flag_o = sub_mode ? ~chain[DATA_W] : chain[DATA_W];
   assign zero   = (sum == '0);

   always_comb begin
      res_o = sum;
      if (dec_i.cls == CLS_LOG) begin
         case (dec_i.lg)
            LOG_AND: res_o = a_i & b_i;
            LOG_OR:  res_o = a_i | b_i;
            default: res_o = a_i ^ b_i;
         endcase
      end
   end

   always_comb begin
      skip_o = 1'b0;
      case (dec_i.cls)
         CLS_ADD, CLS_SUB: skip_o = dec_i.skip_en & flag_o;
         CLS_CMP: begin
            case (dec_i.cmp)
               CMP_EQ:  skip_o = zero;
               CMP_NE:  skip_o = ~zero;
               CMP_GE:  skip_o = ~flag_o;
               default: skip_o = flag_o;
            endcase
         end
         default: skip_o = 1'b0;
      endcase
   end

   // R6
   always_comb begin
      if (dec_i.cls == CLS_CMP) begin
         eq_match_chk: assert (zero == (a_i == b_i));
      end
   end

endmodule

// File: rtl/nib_fwd.sv
module nib_fwd #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 4,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              pend_we_i,
   input  logic [ADDR_W-1:0] pend_addr_i,
   input  logic [DATA_W-1:0] pend_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [DATA_W-1:0] data_o
);

   if (BYPASS_EN) begin : g_bypass
      assign data_o = (pend_we_i && (pend_addr_i == rd_addr_i)) ? pend_data_i : mem_data_i;
   end else begin : g_direct
      logic unused_pend;
      assign unused_pend = pend_we_i ^ (^pend_addr_i) ^ (^pend_data_i) ^ (^rd_addr_i);
      assign data_o = mem_data_i;
   end

endmodule

// File: rtl/nib_alu_exec.sv
module nib_alu_exec
   import nib_alu_pkg::*;
#(
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 2,
   parameter int COL_W     = 4,
   parameter int DATA_W    = 4,
   parameter bit BYPASS_EN = 1'b1,
   localparam int ADDR_W   = BANK_W + ROW_W + COL_W,
   localparam int INSTR_W  = OPC_W + ROW_W + 2 * COL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid_i,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [BANK_W-1:0]  bank_i,
   output logic [ADDR_W-1:0]  mem_m_raddr_o,
   input  logic [DATA_W-1:0]  mem_m_rdata_i,
   output logic [ADDR_W-1:0]  mem_r_raddr_o,
   input  logic [DATA_W-1:0]  mem_r_rdata_i,
   output logic               mem_we_o,
   output logic [ADDR_W-1:0]  mem_waddr_o,
   output logic [DATA_W-1:0]  mem_wdata_o,
   output logic               skip_o,
   output logic               carry_o
);

   if (DATA_W != COL_W) begin : g_bad_width
      $error("nib_alu_exec: immediate field width must equal DATA_W");
   end
   if (BANK_W < 1 || ROW_W < 1) begin : g_bad_addr
      $error("nib_alu_exec: bank and row fields need at least one bit");
   end

   logic [OPC_W-1:0]  opc;
   logic [ROW_W-1:0]  row;
   logic [COL_W-1:0]  col;
   logic [COL_W-1:0]  low_fld;
   logic [ADDR_W-1:0] m_addr;
   logic [ADDR_W-1:0] r_addr;
   logic [ADDR_W-1:0] dest_addr;
   logic [DATA_W-1:0] m_val;
   logic [DATA_W-1:0] r_val;
   logic [DATA_W-1:0] opa;
   logic [DATA_W-1:0] opb;
   logic [DATA_W-1:0] res;
   logic              flag_nxt;
   logic              skip_nxt;
   dec_t              dec;

   assign opc     = instr_i[INSTR_W-1 -: OPC_W];
   assign row     = instr_i[2*COL_W +: ROW_W];
   assign col     = instr_i[COL_W +: COL_W];
   assign low_fld = instr_i[COL_W-1:0];

   assign m_addr = {bank_i, row, col};
   assign r_addr = {{(BANK_W + ROW_W){1'b0}}, low_fld};

   assign mem_m_raddr_o = m_addr;
   assign mem_r_raddr_o = r_addr;

   nib_decode u_decode (
      .opc_i (opc),
      .dec_o (dec)
   );

   nib_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYPASS_EN(BYPASS_EN)) u_fwd_m (
      .pend_we_i   (mem_we_o),
      .pend_addr_i (mem_waddr_o),
      .pend_data_i (mem_wdata_o),
      .rd_addr_i   (m_addr),
      .mem_data_i  (mem_m_rdata_i),
      .data_o      (m_val)
   );

   nib_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYPASS_EN(BYPASS_EN)) u_fwd_r (
      .pend_we_i   (mem_we_o),
      .pend_addr_i (mem_waddr_o),
      .pend_data_i (mem_wdata_o),
      .rd_addr_i   (r_addr),
      .mem_data_i  (mem_r_rdata_i),
      .data_o      (r_val)
   );

   assign opa       = dec.use_imm ? m_val  : r_val;
   assign opb       = dec.use_imm ? low_fld : m_val;
   assign dest_addr = dec.use_imm ? m_addr : r_addr;

   nib_arith #(.DATA_W(DATA_W)) u_arith (
      .dec_i  (dec),
      .a_i    (opa),
      .b_i    (opb),
      .flag_i (carry_o),
      .res_o  (res),
      .flag_o (flag_nxt),
      .skip_o (skip_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we_o    <= 1'b0;
         mem_waddr_o <= '0;
         mem_wdata_o <= '0;
         skip_o      <= 1'b0;
         carry_o     <= 1'b0;
      end else begin
         mem_we_o <= instr_valid_i & dec.wr_en;
         skip_o   <= instr_valid_i & skip_nxt;
         if (instr_valid_i && dec.wr_en) begin
            mem_waddr_o <= dest_addr;
            mem_wdata_o <= res;
         end
         if (instr_valid_i && dec.upd_flag) begin
            carry_o <= flag_nxt;
         end
      end
   end

   // R9
   we_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> $past(instr_valid_i));

   // R9
   skip_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> $past(instr_valid_i));

   // R4
   carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(instr_valid_i) |-> $stable(carry_o));

   // R6
   cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid_i && dec.cls == CLS_CMP) |=> !mem_we_o);

   // R8
   unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid_i && dec.cls == CLS_NONE) |=> (!mem_we_o && !skip_o));

   // R10
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS_EN && mem_we_o && m_addr == mem_waddr_o) |-> (m_val == mem_wdata_o));

endmodule

// File: tb/nib_alu_exec_tb.sv
module nib_alu_exec_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr = '0;
   logic [1:0]  bank = '0;
   logic [7:0]  m_raddr, r_raddr, waddr;
   logic [3:0]  m_rdata, r_rdata, wdata;
   logic        we, skip, carry;

   logic [3:0]  mem     [256];
   logic [3:0]  ref_mem [256];
   logic        ref_c;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic        have_exp = 1'b0;
   logic        exp_we, exp_skip, exp_carry;
   logic [7:0]  exp_addr;
   logic [3:0]  exp_data;
   string       exp_tag, skip_tag;
   logic        prev_we = 1'b0;
   logic [7:0]  prev_addr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nib_alu_exec u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .instr_valid_i (instr_valid),
      .instr_i       (instr),
      .bank_i        (bank),
      .mem_m_raddr_o (m_raddr),
      .mem_m_rdata_i (m_rdata),
      .mem_r_raddr_o (r_raddr),
      .mem_r_rdata_i (r_rdata),
      .mem_we_o      (we),
      .mem_waddr_o   (waddr),
      .mem_wdata_o   (wdata),
      .skip_o        (skip),
      .carry_o       (carry)
   );

   function automatic logic [3:0] init_val(int i);
      return 4'((i * 5 + 3) & 15);
   endfunction

   assign m_rdata = mem[m_raddr];
   assign r_rdata = mem[r_raddr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   task automatic chk(bit ok, string tag, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic check_pending();
      if (have_exp) begin
         chk(we == exp_we, exp_tag, "write strobe", int'(we), int'(exp_we));
         if (exp_we) begin
            chk(waddr == exp_addr, "R1", "write address", int'(waddr), int'(exp_addr));
            chk(wdata == exp_data, exp_tag, "write data", int'(wdata), int'(exp_data));
         end
         chk(skip == exp_skip, skip_tag, "skip", int'(skip), int'(exp_skip));
         chk(carry == exp_carry, "R4", "carry flag", int'(carry), int'(exp_carry));
      end
   endtask

   // Drives one cycle at the falling edge after checking the previous cycle's outputs
   task automatic issue(input bit v, input logic [15:0] ins, input logic [1:0] bk);
      logic [5:0] op;
      logic [7:0] ma, ra, dst;
      logic [3:0] mv, rv, lo, a, b, res;
      logic [4:0] ext;
      logic       f, mi, cin, wr, sk;
      string      tag;
      @(negedge clk);
      check_pending();
      instr_valid = v;
      instr       = ins;
      bank        = bk;
      op  = ins[15:10];
      lo  = ins[3:0];
      ma  = {bk, ins[9:8], ins[7:4]};
      ra  = {4'b0, lo};
      mv  = ref_mem[ma];
      rv  = ref_mem[ra];
      wr  = 1'b0;
      sk  = 1'b0;
      res = '0;
      dst = '0;
      tag = "R8";
      skip_tag = "R8";
      if (!v) begin
         tag = "R9";
         skip_tag = "R9";
      end else if (op[5:4] == 2'b01) begin
         mi  = op[2];
         a   = mi ? mv : rv;
         b   = mi ? lo : mv;
         cin = op[1] & ref_c;
         if (op[3]) begin
            ext = {1'b0, a} - {1'b0, b} - {4'b0, cin};
            tag = "R3";
         end else begin
            ext = {1'b0, a} + {1'b0, b} + {4'b0, cin};
            tag = "R2";
         end
         f     = ext[4];
         res   = ext[3:0];
         dst   = mi ? ma : ra;
         wr    = 1'b1;
         sk    = op[0] & f;
         ref_c = f;
         skip_tag = "R5";
      end else if (op[5:3] == 3'b000) begin
         tag = "R6";
         skip_tag = "R6";
         case (op[2:0])
            3'b100: sk = (rv == mv);
            3'b101: sk = (mv == lo);
            3'b001: sk = (mv != lo);
            3'b110: sk = (rv >= mv);
            3'b111: sk = (mv >= lo);
            3'b011: sk = (mv < lo);
            default: begin tag = "R8"; skip_tag = "R8"; end
         endcase
      end else if (op[5:3] == 3'b001 && op[2:1] != 2'b11) begin
         mi = op[0];
         a  = mi ? mv : rv;
         b  = mi ? lo : mv;
         case (op[2:1])
            2'b00:   res = a & b;
            2'b01:   res = a | b;
            default: res = a ^ b;
         endcase
         dst = mi ? ma : ra;
         wr  = 1'b1;
         tag = "R7";
         skip_tag = "R7";
      end
      if (v && prev_we && (prev_addr == ma || prev_addr == ra) && wr) tag = "R10";
      if (wr) ref_mem[dst] = res;
      exp_we    = wr;
      exp_addr  = dst;
      exp_data  = res;
      exp_skip  = sk;
      exp_carry = ref_c;
      exp_tag   = tag;
      have_exp  = 1'b1;
      prev_we   = wr;
      prev_addr = dst;
   endtask

   function automatic logic [15:0] mk(logic [5:0] op, logic [1:0] row, logic [3:0] col, logic [3:0] lo);
      return {op, row, col, lo};
   endfunction

   initial begin
      repeat (CLK_PERIOD * 100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired before the run completed");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) ref_mem[i] = init_val(i);
      ref_c = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 outputs during reset
      chk(!we && !skip && !carry, "R11", "outputs in reset", int'({we, skip, carry}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 outputs right after reset
      chk(!we && !skip && !carry, "R11", "outputs after reset", int'({we, skip, carry}), 0);

      // R7: clear nibble {1,2,5} with ANDI, then R2 walk through the wrap point
      issue(1, mk(6'b001001, 2'd2, 4'd5, 4'h0), 2'd1);
      issue(1, mk(6'b010101, 2'd2, 4'd5, 4'hF), 2'd1);   // R10 back to back, 0+F no carry
      issue(1, mk(6'b010101, 2'd2, 4'd5, 4'h1), 2'd1);   // R5 F+1 carries and skips
      issue(1, mk(6'b010110, 2'd2, 4'd5, 4'h0), 2'd1);   // R2 carry-in form, 0+0+1
      issue(0, 16'h0, 2'd0);                              // R9 idle cycle
      issue(1, mk(6'b001001, 2'd0, 4'd9, 4'h0), 2'd2);   // clear {2,0,9}
      issue(1, mk(6'b011101, 2'd0, 4'd9, 4'h1), 2'd2);   // R3 0-1 borrows and skips
      issue(1, mk(6'b011110, 2'd0, 4'd9, 4'h0), 2'd2);   // R3 borrow-in F-0-1
      issue(1, mk(6'b011100, 2'd0, 4'd9, 4'hE), 2'd2);   // R3 E-E, no skip variant
      // R6 compares at the boundary values
      issue(1, mk(6'b000101, 2'd0, 4'd9, 4'h0), 2'd2);   // M==0
      issue(1, mk(6'b000001, 2'd0, 4'd9, 4'h0), 2'd2);   // M!=0 false
      issue(1, mk(6'b000111, 2'd0, 4'd9, 4'h0), 2'd2);   // 0>=0
      issue(1, mk(6'b000011, 2'd0, 4'd9, 4'h1), 2'd2);   // 0<1
      issue(1, mk(6'b000011, 2'd0, 4'd9, 4'h0), 2'd2);   // 0<0 false
      // R1 register operands with a non-zero bank, then R6 register compares
      issue(1, mk(6'b010000, 2'd3, 4'd7, 4'h3), 2'd3);
      issue(1, mk(6'b000100, 2'd0, 4'd3, 4'h3), 2'd0);   // r3 == M(0,0,3) same nibble
      issue(1, mk(6'b000110, 2'd0, 4'd4, 4'h3), 2'd0);
      // R7 logic on register destination
      issue(1, mk(6'b001010, 2'd1, 4'd1, 4'h6), 2'd0);
      issue(1, mk(6'b001100, 2'd1, 4'd1, 4'h6), 2'd0);
      issue(1, mk(6'b001101, 2'd1, 4'd1, 4'hA), 2'd0);
      // R8 unknown opcodes
      issue(1, mk(6'b000000, 2'd0, 4'd9, 4'h0), 2'd2);
      issue(1, mk(6'b001110, 2'd1, 4'd1, 4'h5), 2'd0);
      issue(1, mk(6'b100101, 2'd1, 4'd1, 4'h5), 2'd0);

      // random mix with small address spaces to provoke bypass hits
      for (int k = 0; k < 1500; k++) begin
         logic [5:0] op;
         logic [3:0] col, lo;
         bit v;
         v   = ($urandom_range(0, 9) != 0);
         op  = 6'($urandom_range(0, 63));
         if ($urandom_range(0, 2) != 0) op = {2'b01, 4'($urandom_range(0, 15))};
         col = 4'($urandom_range(0, 3));
         lo  = 4'($urandom_range(0, 15));
         issue(v, mk(op, 2'($urandom_range(0, 1)), col, lo), 2'($urandom_range(0, 1)));
      end
      issue(0, 16'h0, 2'd0);
      @(negedge clk);
      check_pending();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule